// File: doc/BRIEF.md
# Prioritized Nested Interrupt Controller

This block collects a parameterized set of interrupt request lines and one non-maskable request, and presents one winning request at a time to a single processor core. Each line has its own enable bit, pending bit and 3-bit priority, where 0 is the most urgent and 7 the least. A small register port lets software enable lines, set or clear pending bits, program priorities, set a priority threshold, choose a priority grouping and disable all maskable lines at once.

The grouping value M splits each priority into 3-M upper bits that decide preemption and M lower bits that only order waiting requests. An accepted interrupt pushes its preemption level onto a level stack. A later request is raised only if it is strictly more urgent than the top of that stack. A request of equal preemption level waits and is raised right after the core signals a return. The request, its number and its non-maskable flag stay stable until the core pulses acknowledge.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Among eligible lines, the one with the numerically smallest 3-bit priority is requested. On a tie, the lowest line number wins.
- R2: A line's pending bit is set on a low-to-high change of the line, sampled at the rising clock edge. A line held high sets its pending bit only once.
- R3: A line is requested only when its enable bit is set. Its pending bit can still become set while the line is disabled. The enable register is at address 0, with bit i belonging to line i.
- R4: With a nonzero threshold (address 4, bits [2:0]), lines whose priority is greater than or equal to the threshold are not requested. A threshold of 0 blocks nothing.
- R5: With global disable set (address 6, bit 0), no maskable line is requested and the enable register keeps its value.
- R6: With grouping M (address 5, bits [1:0]), the preemption level of a line is its priority shifted right by M. A request is raised while a handler is active only if its preemption level is strictly lower than the active one.
- R7: A pending request with the same preemption level as the active handler is raised after the core's return strobe pops that level.
- R8: On acknowledge, the requested line's pending bit clears and its level is pushed. irq_req_o and irq_id_o hold their values until acknowledge, even if a more urgent line arrives.
- R9: A write to set-pending (address 1) sets the pending bits at the 1 positions. A write to clear-pending (address 2) clears them. 0 bits leave the pending bits as they are. A software-set bit is serviced by its priority. Reads at address 1 or 2 return the pending vector.
- R10: A write to address 3 stores wdata[2:0] as the priority of the line given in wdata[15:8]. A read of address 3 returns that line's priority in bits [2:0]. Read data appears on reg_rdata_o one clock after reg_re_i.
- R11: After reset, all enables, pending bits, priorities, the threshold, the grouping and the global disable are zero, and no request is raised.
- R12: A rising edge on nmi_i raises a request with irq_nmi_o set, even under global disable, and preempts any maskable handler. While the non-maskable handler is active, no other request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | N_LINES | Interrupt request lines |
| nmi_i | input | 1 | Non-maskable request |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, valid one clock after the read strobe |
| irq_req_o | output | 1 | Request to the core |
| irq_nmi_o | output | 1 | Current request is the non-maskable one |
| irq_id_o | output | $clog2(N_LINES) | Line number of the current maskable request |
| irq_ack_i | input | 1 | Core accepts the current request |
| irq_ret_i | input | 1 | Core returns from the innermost handler |

## Verification
A line edge or a software set is stored as pending at the next clock edge. The request then registers one edge later, so it appears two edges after the stimulus is first seen. A register write or a return strobe changes eligibility at its own edge, and any new request appears one edge after that. Read data is registered and appears after the edge that samples the strobe. The bench drives inputs and samples outputs on falling edges, and always waits at least those two edges before it compares. The stimulus table runs the arbitration patterns. Directed sequences then cover the threshold, grouping, global disable, held-high lines, the non-maskable request and the stability of a held request.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [2:0] {
    REG_EN   = 3'd0,
    REG_SETP = 3'd1,
    REG_CLRP = 3'd2,
    REG_PRIO = 3'd3,
    REG_THR  = 3'd4,
    REG_GRP  = 3'd5,
    REG_GDIS = 3'd6
  } reg_addr_e;
endpackage

// File: rtl/irqc_line_bank.sv
module irqc_line_bank
  import irqc_pkg::*;
#(
  parameter int N_LINES = 8,
  parameter int PRIO_W  = 3,
  parameter int DATA_W  = 32,
  localparam int IDX_W  = $clog2(N_LINES)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N_LINES-1:0]        irq_i,
  input  logic                      we_i,
  input  logic [2:0]                addr_i,
  input  logic [DATA_W-1:0]         wdata_i,
  input  logic                      ack_clr_i,
  input  logic [IDX_W-1:0]          ack_idx_i,
  output logic [N_LINES-1:0]        en_o,
  output logic [N_LINES-1:0]        pend_o,
  output logic [N_LINES*PRIO_W-1:0] prio_o,
  output logic [PRIO_W-1:0]         prio_sel_o
);
  logic [N_LINES-1:0] irq_q, en_q, pend_q, pend_d;
  logic [N_LINES-1:0] rise, sw_set, sw_clr, hw_clr;
  logic [IDX_W-1:0]   sel_q;
  logic               prio_wr;

  assign rise    = irq_i & ~irq_q;
  assign sw_set  = (we_i && addr_i == REG_SETP) ? wdata_i[N_LINES-1:0] : '0;
  assign sw_clr  = (we_i && addr_i == REG_CLRP) ? wdata_i[N_LINES-1:0] : '0;
  assign prio_wr = we_i && addr_i == REG_PRIO && (wdata_i[15:8] < 8'(N_LINES));

  always_comb begin
    hw_clr = '0;
    if (ack_clr_i) hw_clr[ack_idx_i] = 1'b1;
  end

  // set beats clear when both land in one cycle
  assign pend_d = (pend_q & ~(sw_clr | hw_clr)) | sw_set | rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q  <= '0;
      en_q   <= '0;
      pend_q <= '0;
      sel_q  <= '0;
    end else begin
      irq_q  <= irq_i;
      pend_q <= pend_d;
      if (we_i && addr_i == REG_EN) en_q <= wdata_i[N_LINES-1:0];
      if (prio_wr) sel_q <= wdata_i[8 +: IDX_W];
    end
  end

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    logic [PRIO_W-1:0] prio_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prio_q <= '0;
      else if (prio_wr && wdata_i[15:8] == 8'(i)) prio_q <= wdata_i[PRIO_W-1:0];
    end
    assign prio_o[i*PRIO_W +: PRIO_W] = prio_q;

    // R2
    pend_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pend_q[i]) |-> $past(rise[i] | sw_set[i]));
  end

  assign prio_sel_o = prio_o[sel_q*PRIO_W +: PRIO_W];
  assign en_o       = en_q;
  assign pend_o     = pend_q;

  // R8
  ack_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_clr_i && !rise[ack_idx_i] && !sw_set[ack_idx_i]) |=> !pend_q[$past(ack_idx_i)]);
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
  parameter int N_LINES = 8,
  parameter int PRIO_W  = 3,
  localparam int IDX_W  = $clog2(N_LINES)
) (
  input  logic [N_LINES-1:0]        pend_i,
  input  logic [N_LINES-1:0]        en_i,
  input  logic [N_LINES*PRIO_W-1:0] prio_i,
  input  logic [PRIO_W-1:0]         thr_i,
  input  logic                      gdis_i,
  output logic                      vld_o,
  output logic [IDX_W-1:0]          id_o,
  output logic [PRIO_W-1:0]         prio_o
);
  logic [N_LINES-1:0] elig;

  for (genvar i = 0; i < N_LINES; i++) begin : g_elig
    logic [PRIO_W-1:0] p;
    assign p       = prio_i[i*PRIO_W +: PRIO_W];
    assign elig[i] = pend_i[i] & en_i[i] & ~gdis_i & ((thr_i == '0) | (p < thr_i));
  end

  // ascending scan with strict compare keeps the lowest index on ties
  always_comb begin
    vld_o  = 1'b0;
    id_o   = '0;
    prio_o = '1;
    for (int i = 0; i < N_LINES; i++) begin
      if (elig[i] && (!vld_o || prio_i[i*PRIO_W +: PRIO_W] < prio_o)) begin
        vld_o  = 1'b1;
        id_o   = IDX_W'(i);
        prio_o = prio_i[i*PRIO_W +: PRIO_W];
      end
    end
  end

  // R3
  always_comb begin
    if (vld_o) begin
      win_enabled_chk: assert (en_i[id_o] && pend_i[id_o]);
    end
  end
endmodule

// File: rtl/irqc_lvl_stack.sv
module irqc_lvl_stack #(
  parameter int LVL_W    = 4,
  parameter int DEPTH    = 9,
  parameter int LVL_IDLE = 9,
  localparam int SP_W    = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [LVL_W-1:0] push_lvl_i,
  input  logic             pop_i,
  output logic [LVL_W-1:0] top_o
);
  logic [LVL_W-1:0] stk_q [DEPTH];
  logic [SP_W-1:0]  sp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q <= '0;
      for (int i = 0; i < DEPTH; i++) stk_q[i] <= '0;
    end else if (push_i && pop_i) begin
      if (sp_q != '0) stk_q[sp_q-1'b1] <= push_lvl_i;
      else begin
        stk_q[0] <= push_lvl_i;
        sp_q     <= SP_W'(1);
      end
    end else if (push_i) begin
      if (sp_q < SP_W'(DEPTH)) begin
        stk_q[sp_q] <= push_lvl_i;
        sp_q        <= sp_q + 1'b1;
      end
    end else if (pop_i && sp_q != '0) begin
      sp_q <= sp_q - 1'b1;
    end
  end

  assign top_o = (sp_q == '0) ? LVL_W'(LVL_IDLE) : stk_q[sp_q-1'b1];

  // R6
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i) |-> sp_q < SP_W'(DEPTH));

  // R6
  nest_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i) |-> push_lvl_i < top_o);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int N_LINES = 8,
  parameter int PRIO_W  = 3,
  parameter int DATA_W  = 32,
  localparam int IDX_W  = $clog2(N_LINES),
  localparam int GRP_W  = $clog2(PRIO_W + 1),
  localparam int LVL_W  = PRIO_W + 1,
  localparam int STK_D  = (1 << PRIO_W) + 1,
  localparam int LVL_IDLE = (1 << PRIO_W) + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] irq_i,
  input  logic               nmi_i,
  input  logic               reg_we_i,
  input  logic               reg_re_i,
  input  logic [2:0]         reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  output logic               irq_req_o,
  output logic               irq_nmi_o,
  output logic [IDX_W-1:0]   irq_id_o,
  input  logic               irq_ack_i,
  input  logic               irq_ret_i
);
  logic [N_LINES-1:0]        en, pend;
  logic [N_LINES*PRIO_W-1:0] prio_flat;
  logic [PRIO_W-1:0]         prio_sel, thr_q, cand_prio;
  logic [GRP_W-1:0]          grp_q;
  logic                      gdis_q, nmi_q, nmi_pend_q;
  logic                      cand_vld, want_nmi, want_irq, accept;
  logic [IDX_W-1:0]          cand_id, id_q;
  logic [LVL_W-1:0]          cand_lvl, lvl_q, active_lvl;
  logic                      req_q, req_nmi_q;
  logic [DATA_W-1:0]         rdata_q;

  irqc_line_bank #(.N_LINES(N_LINES), .PRIO_W(PRIO_W), .DATA_W(DATA_W)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .irq_i      (irq_i),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .ack_clr_i  (accept && !req_nmi_q),
    .ack_idx_i  (id_q),
    .en_o       (en),
    .pend_o     (pend),
    .prio_o     (prio_flat),
    .prio_sel_o (prio_sel)
  );

  irqc_arbiter #(.N_LINES(N_LINES), .PRIO_W(PRIO_W)) u_arb (
    .pend_i (pend),
    .en_i   (en),
    .prio_i (prio_flat),
    .thr_i  (thr_q),
    .gdis_i (gdis_q),
    .vld_o  (cand_vld),
    .id_o   (cand_id),
    .prio_o (cand_prio)
  );

  irqc_lvl_stack #(.LVL_W(LVL_W), .DEPTH(STK_D), .LVL_IDLE(LVL_IDLE)) u_stk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (accept),
    .push_lvl_i (lvl_q),
    .pop_i      (irq_ret_i),
    .top_o      (active_lvl)
  );

  // level 0 is reserved for the non-maskable request
  assign cand_lvl = (LVL_W'({1'b0, cand_prio}) >> grp_q) + LVL_W'(1);
  assign want_nmi = nmi_pend_q && active_lvl != '0;
  assign want_irq = cand_vld && cand_lvl < active_lvl;
  assign accept   = req_q && irq_ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_q      <= '0;
      grp_q      <= '0;
      gdis_q     <= 1'b0;
      nmi_q      <= 1'b0;
      nmi_pend_q <= 1'b0;
      req_q      <= 1'b0;
      req_nmi_q  <= 1'b0;
      id_q       <= '0;
      lvl_q      <= '0;
      rdata_q    <= '0;
    end else begin
      nmi_q <= nmi_i;
      if (nmi_i && !nmi_q) nmi_pend_q <= 1'b1;
      else if (accept && req_nmi_q) nmi_pend_q <= 1'b0;

      if (reg_we_i) begin
        unique case (reg_addr_i)
          REG_THR:  thr_q  <= reg_wdata_i[PRIO_W-1:0];
          REG_GRP:  grp_q  <= reg_wdata_i[GRP_W-1:0];
          REG_GDIS: gdis_q <= reg_wdata_i[0];
          default: ;
        endcase
      end

      if (!req_q) begin
        if (want_nmi) begin
          req_q     <= 1'b1;
          req_nmi_q <= 1'b1;
          lvl_q     <= '0;
        end else if (want_irq) begin
          req_q     <= 1'b1;
          req_nmi_q <= 1'b0;
          id_q      <= cand_id;
          lvl_q     <= cand_lvl;
        end
      end else if (irq_ack_i) begin
        req_q <= 1'b0;
      end

      if (reg_re_i) begin
        unique case (reg_addr_i)
          REG_EN:   rdata_q <= DATA_W'(en);
          REG_SETP,
          REG_CLRP: rdata_q <= DATA_W'(pend);
          REG_PRIO: rdata_q <= DATA_W'(prio_sel);
          REG_THR:  rdata_q <= DATA_W'(thr_q);
          REG_GRP:  rdata_q <= DATA_W'(grp_q);
          REG_GDIS: rdata_q <= DATA_W'(gdis_q);
          default:  rdata_q <= '0;
        endcase
      end
    end
  end

  assign irq_req_o   = req_q;
  assign irq_nmi_o   = req_q && req_nmi_q;
  assign irq_id_o    = id_q;
  assign reg_rdata_o = rdata_q;

  // R8
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q && !irq_ack_i) |=> (req_q && $stable(id_q) && $stable(req_nmi_q)));

  // R6
  preempt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |-> lvl_q < active_lvl);

  // R5
  gdis_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gdis_q && !req_q && !(reg_we_i && reg_addr_i == REG_GDIS)) |=> (!req_q || req_nmi_q));

  // R12
  nmi_lvl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q && req_nmi_q) |-> lvl_q == '0);
endmodule

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb_top;
  localparam int N = 8;
  localparam logic [2:0] A_EN = 3'd0, A_SETP = 3'd1, A_CLRP = 3'd2, A_PRIO = 3'd3,
                         A_THR = 3'd4, A_GRP = 3'd5, A_GDIS = 3'd6;
  // {pattern[15:8], expect_req[7], id[2:0]}
  localparam logic [15:0] VEC [8] = '{16'h0180, 16'h0681, 16'h0482, 16'h1884,
                                      16'hA887, 16'h4186, 16'h0000, 16'h2883};
  localparam logic [2:0] PRIOS [8] = '{3'd4, 3'd2, 3'd2, 3'd6, 3'd0, 3'd7, 3'd3, 3'd5};

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic [N-1:0] irq_i = '0;
  logic        nmi_i = 1'b0, reg_we_i = 1'b0, reg_re_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0, reg_rdata_o;
  logic        irq_req_o, irq_nmi_o, irq_ack_i = 1'b0, irq_ret_i = 1'b0;
  logic [2:0]  irq_id_o;
  int checks = 0, fails = 0, cyc = 0;
  logic [31:0] rv;

  prio_irq_ctrl #(.N_LINES(N)) dut_i (.*);

  always #5 clk_i = ~clk_i;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    tick(1);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_re_i = 1'b1; reg_addr_i = a;
    tick(1);
    reg_re_i = 1'b0;
    d = reg_rdata_o;
  endtask

  task automatic pulse(input logic [N-1:0] m);
    irq_i = m; tick(1); irq_i = '0;
  endtask

  task automatic ack();
    irq_ack_i = 1'b1; tick(1); irq_ack_i = 1'b0;
  endtask

  task automatic ret();
    irq_ret_i = 1'b1; tick(1); irq_ret_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      finish_run();
    end
  end

  initial begin
    tick(2);
    rst_ni = 1'b1;
    tick(1);
    // R11 reset state
    chk("R11 req", {31'b0, irq_req_o}, 0);
    rd(A_EN, rv);   chk("R11 enable", rv, 0);
    rd(A_SETP, rv); chk("R11 pending", rv, 0);
    rd(A_THR, rv);  chk("R11 threshold", rv, 0);

    for (int i = 0; i < N; i++) wr(A_PRIO, (i << 8) | PRIOS[i]);
    wr(A_EN, 32'hFF);

    // R1 arbitration table
    for (int v = 0; v < 8; v++) begin
      wr(A_CLRP, 32'hFF);
      pulse(VEC[v][15:8]);
      tick(2);
      chk($sformatf("R1 req vec%0d", v), {31'b0, irq_req_o}, {31'b0, VEC[v][7]});
      if (VEC[v][7]) begin
        chk($sformatf("R1 id vec%0d", v), {29'b0, irq_id_o}, {29'b0, VEC[v][2:0]});
        ack();
        wr(A_CLRP, 32'hFF);
        ret();
      end
      tick(1);
    end

    // R2 held-high line pends once; R8 ack clears pending
    irq_i = 8'h01; tick(2);
    chk("R2 first req", {irq_req_o, 28'b0, irq_id_o}, 32'h8000_0000);
    ack(); tick(1);
    rd(A_SETP, rv); chk("R8 pend cleared on ack", rv, 0);
    ret(); tick(2);
    chk("R2 held high no repend", {31'b0, irq_req_o}, 0);
    irq_i = 8'h00; tick(1); irq_i = 8'h01; tick(2);
    chk("R2 new edge", {irq_req_o, 28'b0, irq_id_o}, 32'h8000_0000);
    ack(); irq_i = '0; ret(); tick(1);

    // R3 disabled line pends without request
    wr(A_EN, 32'hFE);
    pulse(8'h01); tick(2);
    chk("R3 disabled no req", {31'b0, irq_req_o}, 0);
    rd(A_SETP, rv); chk("R3 pend while disabled", rv, 32'h01);
    wr(A_EN, 32'hFF); tick(2);
    chk("R3 enabled req", {irq_req_o, 28'b0, irq_id_o}, 32'h8000_0000);
    ack(); ret(); tick(1);

    // R4 threshold
    wr(A_THR, 4);
    pulse(8'h41); tick(2);
    chk("R4 threshold pick", {irq_req_o, 28'b0, irq_id_o}, 32'h8000_0006);
    ack(); wr(A_CLRP, 32'hFF); ret();
    pulse(8'h01); tick(2);
    chk("R4 equal prio blocked", {31'b0, irq_req_o}, 0);
    wr(A_THR, 0); tick(2);
    chk("R4 zero threshold", {irq_req_o, 28'b0, irq_id_o}, 32'h8000_0000);
    ack(); ret(); tick(1);

    // R5 global disable, R12 non-maskable
    wr(A_GDIS, 1);
    pulse(8'h10); tick(2);
    chk("R5 gdis blocks", {31'b0, irq_req_o}, 0);
    rd(A_EN, rv); chk("R5 enables kept", rv, 32'hFF);
    nmi_i = 1'b1; tick(1); nmi_i = 1'b0; tick(2);
    chk("R12 nmi req", {30'b0, irq_req_o, irq_nmi_o}, 3);
    ack();
    wr(A_GDIS, 0); tick(2);
    chk("R12 nmi not preempted", {31'b0, irq_req_o}, 0);
    ret(); tick(2);
    chk("R12 after nmi", {irq_req_o, irq_nmi_o, 27'b0, irq_id_o}, 32'h8000_0004);
    ack(); ret(); tick(1);

    // R6/R7 grouping with M=2
    wr(A_GRP, 2);
    pulse(8'h80); tick(2); ack();
    pulse(8'h40); tick(2);
    chk("R6 group preempt", {irq_req_o, 28'b0, irq_id_o}, 32'h8000_0006);
    ack();
    pulse(8'h02); tick(2);
    chk("R7 same group waits", {31'b0, irq_req_o}, 0);
    ret(); tick(2);
    chk("R7 tail chain", {irq_req_o, 28'b0, irq_id_o}, 32'h8000_0001);
    ack(); ret(); ret(); tick(1);
    // M=3: single preemption level
    wr(A_GRP, 3);
    pulse(8'h20); tick(2); ack();
    pulse(8'h10); tick(2);
    chk("R6 no preempt M3", {31'b0, irq_req_o}, 0);
    ret(); tick(2);
    chk("R7 chained M3", {irq_req_o, 28'b0, irq_id_o}, 32'h8000_0004);
    ack(); ret(); wr(A_GRP, 0); tick(1);

    // R9 software set/clear
    wr(A_GDIS, 1);
    wr(A_SETP, 32'h0C);
    rd(A_SETP, rv); chk("R9 set", rv, 32'h0C);
    wr(A_CLRP, 32'h00);
    rd(A_CLRP, rv); chk("R9 zero clear ignored", rv, 32'h0C);
    wr(A_SETP, 32'h00);
    rd(A_SETP, rv); chk("R9 zero set ignored", rv, 32'h0C);
    wr(A_CLRP, 32'h04);
    rd(A_SETP, rv); chk("R9 clear", rv, 32'h08);
    wr(A_GDIS, 0); tick(2);
    chk("R9 sw pend serviced", {irq_req_o, 28'b0, irq_id_o}, 32'h8000_0003);
    ack(); ret(); tick(1);

    // R8 request held stable until acknowledge
    pulse(8'h20); tick(2);
    chk("R8 held id", {irq_req_o, 28'b0, irq_id_o}, 32'h8000_0005);
    pulse(8'h10); tick(2);
    chk("R8 stays stable", {irq_req_o, 28'b0, irq_id_o}, 32'h8000_0005);
    ack(); tick(2);
    chk("R8 next after ack", {irq_req_o, 28'b0, irq_id_o}, 32'h8000_0004);
    ack(); ret(); ret(); tick(1);

    // R10 register map
    wr(A_PRIO, (3 << 8) | 1);
    rd(A_PRIO, rv); chk("R10 prio readback", rv, 1);
    wr(A_THR, 5);
    rd(A_THR, rv); chk("R10 thr readback", rv, 5);
    wr(A_GRP, 2);
    rd(A_GRP, rv); chk("R10 grp readback", rv, 2);

    finish_run();
  end
endmodule